// File: doc/BRIEF.md
# Program Counter and Next-Fetch Unit

This block owns the program counter of a 32-bit processor whose instructions are one 4-byte word each. Every cycle it takes the decoded control class of the instruction at the current PC, the two register operands read for that instruction, the 16-bit branch offset and the 26-bit jump field. From these it picks the next fetch address. The supported flows are:

- sequential flow;
- branch when the operands are equal, and branch when they differ;
- a jump within the current 256 MB region;
- a jump that also saves a return address;
- a jump to an address held in a register.

The PC is a register that updates on the rising clock edge. The return-address write request and the misalignment flag are combinational outputs for the instruction presented in the same cycle. A stall input freezes the PC and suppresses both side effects, so the decode stage can wait on hazards. Branch delay slots, prediction and exceptions sit outside this block.

Top module: `npc_flow_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, the PC reads 0x00001000, and the link write request and misalignment flag are low.
- R2: Class code 0 (sequential) advances the PC by 4 at the next edge. The unused codes 6 and 7 behave the same way.
- R3: Class code 1 (branch-if-equal) loads PC+4 plus the sign-extended offset times 4 when operand A equals operand B. Otherwise it loads PC+4.
- R4: Class code 2 (branch-if-not-equal) takes the branch only when the operands differ. Otherwise it loads PC+4.
- R5: The offset is signed two's complement counted in instructions. 0x7FFF reaches 32767 instructions past PC+4, and 0x8000 reaches 32768 instructions before PC+4, with 32-bit wraparound.
- R6: Class code 3 (region jump) loads {PC+4 bits 31:28, jump field, 2'b00}.
- R7: Class code 4 (jump-and-link) loads the same target as R6. In the same cycle it raises the link write request with register index 31 and link value PC+4.
- R8: Class code 5 (register jump) loads operand A when its two low bits are zero, so the PC always stays word-aligned.
- R9: Class code 5 with either low bit of operand A set raises the misalignment flag in that cycle, and the PC keeps its value.
- R10: While stall is high, the PC holds its value and both the link write request and the misalignment flag stay low, whatever the class.
- R11: The link write request is raised for no class other than jump-and-link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze PC and suppress side effects |
| ctl_kind | input | 3 | Control class code of the current instruction |
| opnd_a | input | 32 | First register operand (also register-jump target) |
| opnd_b | input | 32 | Second register operand |
| br_off | input | 16 | Signed branch offset in instructions |
| jmp_field | input | 26 | Region jump word index |
| pc_o | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Register index for the return address |
| link_val | output | 32 | Return address value |
| misalign | output | 1 | Register-jump target not word-aligned |

## Verification
The link request, link index, link value and misalignment flag depend only on the inputs and the current PC. They are therefore due in the same cycle the instruction is presented. The bench samples them one time unit after driving the inputs on the falling edge. The PC is due one rising edge later, so the bench compares it with its reference model on the following falling edge. The reference model is updated at that same rising edge, and every instruction is held for exactly one cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned KIND_W    = 3;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned WORD_SH   = 2;

    localparam logic [XLEN-1:0]      BOOT_PC = 32'h0000_1000;
    localparam logic [REG_IDX_W-1:0] RET_REG = 5'd31;

    typedef enum logic [KIND_W-1:0] {
        K_SEQ  = 3'd0,
        K_BEQ  = 3'd1,
        K_BNE  = 3'd2,
        K_JMP  = 3'd3,
        K_JAL  = 3'd4,
        K_JREG = 3'd5
    } flow_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] region;
    } target_set_t;

    typedef struct packed {
        logic            load;
        logic [XLEN-1:0] dest;
        logic            link;
        logic            misalign;
    } decision_t;

    function automatic logic word_aligned(input logic [XLEN-1:0] a);
        return (a[WORD_SH-1:0] == '0);
    endfunction

endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
#(
    parameter int unsigned OFF_W = 16,
    parameter int unsigned JF_W  = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic [JF_W-1:0]  jf,
    output target_set_t      tg
);
    localparam int unsigned EXT_W    = XLEN - OFF_W - WORD_SH;
    localparam int unsigned REGION_W = XLEN - JF_W - WORD_SH;

    logic [XLEN-1:0] step;
    logic [XLEN-1:0] disp;

    always_comb begin
        step      = pc + XLEN'(4);
        disp      = {{EXT_W{off[OFF_W-1]}}, off, {WORD_SH{1'b0}}};
        tg.seq    = step;
        tg.branch = step + disp;
        tg.region = {step[XLEN-1 -: REGION_W], jf, {WORD_SH{1'b0}}};
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              stall,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  target_set_t       tg,
    output decision_t         dec
);
    logic same;

    always_comb begin
        same         = (opa == opb);
        dec.load     = 1'b1;
        dec.dest     = tg.seq;
        dec.link     = 1'b0;
        dec.misalign = 1'b0;
        case (flow_kind_e'(kind))
            K_BEQ:  if (same)  dec.dest = tg.branch;
            K_BNE:  if (!same) dec.dest = tg.branch;
            K_JMP:  dec.dest = tg.region;
            K_JAL: begin
                dec.dest = tg.region;
                dec.link = 1'b1;
            end
            K_JREG: begin
                if (word_aligned(opa)) begin
                    dec.dest = opa;
                end else begin
                    dec.load     = 1'b0;
                    dec.misalign = 1'b1;
                end
            end
            default: dec.dest = tg.seq;
        endcase
        if (stall) begin
            dec.load     = 1'b0;
            dec.link     = 1'b0;
            dec.misalign = 1'b0;
        end
    end

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = BOOT_PC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [XLEN-1:0] nxt,
    output logic [XLEN-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst)       pc <= RESET_PC;
        else if (load) pc <= nxt;
    end
endmodule

// File: rtl/npc_flow_unit.sv
module npc_flow_unit
    import npc_pkg::*;
#(
    parameter int unsigned     OFF_W    = 16,
    parameter int unsigned     JF_W     = 26,
    parameter logic [XLEN-1:0] RESET_PC = BOOT_PC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall,
    input  logic [KIND_W-1:0]    ctl_kind,
    input  logic [XLEN-1:0]      opnd_a,
    input  logic [XLEN-1:0]      opnd_b,
    input  logic [OFF_W-1:0]     br_off,
    input  logic [JF_W-1:0]      jmp_field,
    output logic [XLEN-1:0]      pc_o,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]      link_val,
    output logic                 misalign
);
    target_set_t tg;
    decision_t   dec;
    logic [XLEN-1:0] pc_q;

    npc_target_gen #(.OFF_W(OFF_W), .JF_W(JF_W)) u_tgen (
        .pc  (pc_q),
        .off (br_off),
        .jf  (jmp_field),
        .tg  (tg)
    );

    npc_select u_sel (
        .kind  (ctl_kind),
        .stall (stall),
        .opa   (opnd_a),
        .opb   (opnd_b),
        .tg    (tg),
        .dec   (dec)
    );

    npc_pc_reg #(.RESET_PC(RESET_PC)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .load (dec.load),
        .nxt  (dec.dest),
        .pc   (pc_q)
    );

    assign pc_o     = pc_q;
    assign link_we  = dec.link & ~rst;
    assign link_idx = RET_REG;
    assign link_val = tg.seq;
    assign misalign = dec.misalign & ~rst;

endmodule

// File: rtl/npc_flow_chk.sv
module npc_flow_chk
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = BOOT_PC
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 stall,
    input logic [KIND_W-1:0]    ctl_kind,
    input logic [XLEN-1:0]      pc_o,
    input logic                 link_we,
    input logic [REG_IDX_W-1:0] link_idx,
    input logic [XLEN-1:0]      link_val,
    input logic                 misalign
);
    AST_BOOT_PC: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_o == RESET_PC && !link_we && !misalign)); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!stall && ctl_kind == 3'd0) |=> (pc_o == $past(pc_o) + 32'd4)); // R2
    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_val == pc_o + 32'd4 && link_idx == 5'd31)); // R7
    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00); // R8
    AST_MISALIGN_HOLD: assert property (@(posedge clk) disable iff (rst)
        misalign |=> $stable(pc_o)); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc_o)); // R10
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!link_we && !misalign)); // R10
    AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (ctl_kind == 3'd4)); // R11
endmodule

bind npc_flow_unit npc_flow_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .ctl_kind (ctl_kind),
    .pc_o     (pc_o),
    .link_we  (link_we),
    .link_idx (link_idx),
    .link_val (link_val),
    .misalign (misalign)
);

// File: tb/npc_flow_unit_tb.sv
module npc_flow_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [2:0]  ctl_kind = 3'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] pc_o, link_val;
    logic [4:0]  link_idx;
    logic        link_we, misalign;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] model_pc;

    always #5 clk = ~clk;

    npc_flow_unit u_dut (
        .clk(clk), .rst(rst), .stall(stall), .ctl_kind(ctl_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .br_off(br_off), .jmp_field(jmp_field),
        .pc_o(pc_o), .link_we(link_we), .link_idx(link_idx),
        .link_val(link_val), .misalign(misalign)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One instruction held for one cycle; inputs driven at negedge.
    task automatic issue(input string req, input logic [2:0] k, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] off,
                         input logic [25:0] jf, input logic st);
        logic [31:0] nxt, step;
        logic exp_link, exp_mis;
        ctl_kind = k; opnd_a = a; opnd_b = b; br_off = off; jmp_field = jf; stall = st;
        step = model_pc + 32'd4;
        nxt = step; exp_link = 0; exp_mis = 0;
        case (k)
            3'd1: if (a == b) nxt = step + {{14{off[15]}}, off, 2'b00};
            3'd2: if (a != b) nxt = step + {{14{off[15]}}, off, 2'b00};
            3'd3: nxt = {step[31:28], jf, 2'b00};
            3'd4: begin nxt = {step[31:28], jf, 2'b00}; exp_link = 1; end
            3'd5: if (a[1:0] == 2'b00) nxt = a; else begin nxt = model_pc; exp_mis = 1; end
            default: nxt = step;
        endcase
        if (st) begin nxt = model_pc; exp_link = 0; exp_mis = 0; end
        #1;
        check({req, " link_we"}, {31'd0, link_we}, {31'd0, exp_link});
        check({req, " misalign"}, {31'd0, misalign}, {31'd0, exp_mis});
        if (exp_link) begin
            check({req, " link_idx"}, {27'd0, link_idx}, 32'd31);
            check({req, " link_val"}, link_val, step);
        end
        @(posedge clk);
        model_pc = nxt;
        @(negedge clk);
        check({req, " pc"}, pc_o, model_pc);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pc in reset", pc_o, 32'h0000_1000);
        check("R1 link_we in reset", {31'd0, link_we}, 32'd0);
        rst = 1'b0;
        #1;
        check("R1 pc after reset", pc_o, 32'h0000_1000);
        check("R1 misalign after reset", {31'd0, misalign}, 32'd0);
        model_pc = 32'h0000_1000;

        issue("R2 seq", 3'd0, 0, 0, 16'h0010, 26'h0, 0);
        issue("R2 seq code6", 3'd6, 1, 1, 16'h0010, 26'h0, 0);
        issue("R2 seq code7", 3'd7, 0, 0, 16'h0000, 26'h3, 0);
        issue("R3 beq taken", 3'd1, 32'h55, 32'h55, 16'h0004, 26'h0, 0);
        issue("R3 beq not taken", 3'd1, 32'h55, 32'h56, 16'h0004, 26'h0, 0);
        issue("R4 bne taken", 3'd2, 32'h1, 32'h2, 16'hFFFE, 26'h0, 0);
        issue("R4 bne not taken", 3'd2, 32'h7, 32'h7, 16'h0040, 26'h0, 0);
        issue("R5 max forward", 3'd1, 0, 0, 16'h7FFF, 26'h0, 0);
        issue("R5 max backward", 3'd2, 0, 9, 16'h8000, 26'h0, 0);
        issue("R8 jreg aligned", 3'd5, 32'hA000_0100, 0, 0, 26'h0, 0);
        issue("R6 region jump", 3'd3, 0, 0, 0, 26'h2AB_CDEF, 0);
        issue("R7 jal", 3'd4, 0, 0, 0, 26'h000_1234, 0);
        issue("R11 jreg no link", 3'd5, 32'h0000_2000, 0, 0, 26'h0, 0);
        issue("R9 jreg misaligned lo", 3'd5, 32'h0000_3001, 0, 0, 26'h0, 0);
        issue("R9 jreg misaligned hi", 3'd5, 32'h0000_3002, 0, 0, 26'h0, 0);
        issue("R10 stall jal", 3'd4, 0, 0, 0, 26'h0FF_FFFF, 1);
        issue("R10 stall beq", 3'd1, 3, 3, 16'h0100, 26'h0, 1);
        issue("R10 stall misaligned jreg", 3'd5, 32'h0000_0003, 0, 0, 26'h0, 1);
        issue("R11 bne no link", 3'd2, 1, 2, 16'h0001, 26'h0, 0);
        issue("R7 jal again", 3'd4, 0, 0, 0, 26'h3FF_FFFF, 0);
        issue("R2 seq after jal", 3'd0, 0, 0, 0, 26'h0, 0);

        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 pc re-reset", pc_o, 32'h0000_1000);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule